// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block takes a snapshot of the running calendar time when an external tamper line is pulled low. The live time arrives as six BCD fields: seconds, minutes, hours, day of month, month and two-digit year. The tamper pin passes through a two-stage synchronizer. Its falling edge copies all six fields into snapshot registers on one clock edge, so a carry in the live counter cannot tear the record. Every capture sets two event flags, which sit in two separate control registers. Software clears each flag on its own by writing a zero to that bit. When the interrupt enable is set, an active-low interrupt stays asserted for as long as either flag is set.

A small FSM decides whether a capture may happen. In S_ARMED a synchronized falling edge is captured. The FSM moves to S_LOCKED when the keep-first mode bit is set and a flag is set, or a capture is in progress. While it is in S_LOCKED, later events are dropped. It returns to S_ARMED once both flags are clear or the mode bit is cleared. Setting the disable bit moves the FSM from any state to S_OFF. Clearing the disable bit takes it to S_LOCKED or S_ARMED, using the same rule as above. The state changes one clock after the register it depends on.

Register map, 4-bit address, 8-bit data, combinational read:
- Address 0: flag 1 at bit 4.
- Address 1: flag 2 at bit 5 and interrupt enable at bit 2.
- Address 2: keep-first mode at bit 7 and capture disable at bit 6.
- Addresses 3 to 8: snapshot of seconds, minutes, hours, day, month and year, in that order. These are read-only.

Top module: `tamper_stamp`

## Requirements
- R1: After reset, every register reads 0, irq_n is 1 and the FSM is in S_ARMED, so capture is enabled.
- R2: A falling edge on tamper_n captures the live fields sampled at the third rising clock edge, counting the first edge that samples tamper_n low as edge one. The fields are masked to 7 bits (seconds, minutes), 6 bits (hours, day), 5 bits (month) and 8 bits (year), and appear at addresses 3 to 8.
- R3: Every capture sets flag 1 (address 0 bit 4) and flag 2 (address 1 bit 5).
- R4: Writing 0 to a flag bit clears only that flag. Writing 1 to a flag bit leaves it unchanged.
- R5: While the disable bit (address 2 bit 6) is 1, tamper events change neither the snapshot nor the flags. Clearing the bit enables capture again.
- R6: With keep-first mode on (address 2 bit 7 = 1), an event that occurs while either flag is set leaves the snapshot and the flags unchanged.
- R7: With keep-first mode off, each event overwrites the snapshot.
- R8: irq_n is 0 exactly when the interrupt enable (address 1 bit 2) is 1 and at least one flag is set.
- R9: A rising edge on tamper_n, or a steady level, causes no capture.
- R10: When a capture and a software write that clears a flag fall in the same cycle, the flag ends up set.
- R11: Addresses 9 to 15 read 0, and writes to the snapshot addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_n | input | 1 | Asynchronous tamper line, event on falling edge |
| live_sec | input | 7 | Live seconds, BCD |
| live_min | input | 7 | Live minutes, BCD |
| live_hour | input | 6 | Live hours, BCD |
| live_day | input | 6 | Live day of month, BCD |
| live_mon | input | 5 | Live month, BCD |
| live_year | input | 8 | Live two-digit year, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A hardware capture and a software write that clears a flag can land on the same clock edge, so both try to update the same flag register in one cycle. The bench drives tamper_n low and, counting synchronizer stages, places a clearing write to address 0 exactly on the capture edge. It then requires the flag to read back as set and the snapshot to hold the fields changed in that cycle. The bench also checks that each field is sampled on the exact capture edge: it changes the live fields one cycle before and one cycle after that edge, across a sweep of field values that includes the all-ones pattern.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 4;
    localparam int N_FIELDS = 6;

    localparam logic [ADDR_W-1:0] A_FLAG1 = 4'd0;
    localparam logic [ADDR_W-1:0] A_FLAG2 = 4'd1;
    localparam logic [ADDR_W-1:0] A_CFG   = 4'd2;
    localparam int                A_SNAP0 = 3;

    localparam int B_FLAG1 = 4;
    localparam int B_FLAG2 = 5;
    localparam int B_IEN   = 2;
    localparam int B_DIS   = 6;
    localparam int B_MODE  = 7;

    typedef enum logic [1:0] {
        S_ARMED  = 2'd0,
        S_LOCKED = 2'd1,
        S_OFF    = 2'd2
    } cap_state_t;

    typedef logic [N_FIELDS-1:0][REG_W-1:0] field_vec_t;

    // Significant bits of each snapshot field, in address order.
    function automatic logic [REG_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2, 3:    return 8'h3F;
            4:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/tstamp_sync.sv
module tstamp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign fall = last_q & ~chain_q[STAGES-1];

    // R9
    no_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(chain_q[STAGES-1]));
endmodule

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
    import tstamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic              cap_go,
    output logic              flag1_q,
    output logic              flag2_q,
    output logic              ien_q,
    output logic              mode_q,
    output logic              dis_q,
    output logic              irq_n
);
    cap_state_t cur_q, nxt;
    logic       any_flag, wr_f1, wr_f2, wr_cfg;

    assign any_flag = flag1_q | flag2_q;
    assign wr_f1    = we && (addr == A_FLAG1);
    assign wr_f2    = we && (addr == A_FLAG2);
    assign wr_cfg   = we && (addr == A_CFG);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= S_ARMED;
        else        cur_q <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            S_ARMED: begin
                if (dis_q)                             nxt = S_OFF;
                else if (mode_q && (any_flag || cap_go)) nxt = S_LOCKED;
            end
            S_LOCKED: begin
                if (dis_q)                      nxt = S_OFF;
                else if (!mode_q || !any_flag)  nxt = S_ARMED;
            end
            S_OFF: begin
                if (!dis_q) nxt = (mode_q && any_flag) ? S_LOCKED : S_ARMED;
            end
            default: nxt = S_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        cap_go = fall && (cur_q == S_ARMED);
        irq_n  = !(ien_q && any_flag);
    end

    // Flags and configuration; a capture wins over a clearing write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
            ien_q   <= 1'b0;
            mode_q  <= 1'b0;
            dis_q   <= 1'b0;
        end else begin
            if (cap_go)                         flag1_q <= 1'b1;
            else if (wr_f1 && !wdata[B_FLAG1])  flag1_q <= 1'b0;
            if (cap_go)                         flag2_q <= 1'b1;
            else if (wr_f2 && !wdata[B_FLAG2])  flag2_q <= 1'b0;
            if (wr_f2)  ien_q <= wdata[B_IEN];
            if (wr_cfg) begin
                mode_q <= wdata[B_MODE];
                dis_q  <= wdata[B_DIS];
            end
        end
    end

    // R3
    flags_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_go |=> (flag1_q && flag2_q));
    // R4
    flag1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_f1 && !wdata[B_FLAG1] && !cap_go) |=> !flag1_q);
    // R5
    off_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_q) |-> !cap_go);
    // R6
    locked_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q && any_flag && !dis_q) && mode_q && any_flag) |-> !cap_go);
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_flag |-> irq_n);
endmodule

// File: rtl/tstamp_snap.sv
module tstamp_snap
    import tstamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_go,
    input  field_vec_t live,
    output field_vec_t snap_q
);
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      snap_q[i] <= '0;
            else if (cap_go) snap_q[i] <= live[i] & field_mask(i);
        end

        // R2
        field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_go |=> (snap_q[i] == ($past(live[i]) & field_mask(i))));
        // R9
        field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_go |=> $stable(snap_q[i]));
    end
endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp
    import tstamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tamper_n,
    input  logic [6:0]        live_sec,
    input  logic [6:0]        live_min,
    input  logic [5:0]        live_hour,
    input  logic [5:0]        live_day,
    input  logic [4:0]        live_mon,
    input  logic [7:0]        live_year,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_n
);
    localparam int SYNC_STAGES = 2;

    logic       fall, cap_go, flag1, flag2, ien, mode, dis;
    field_vec_t live_v, snap;

    assign live_v[0] = {1'b0, live_sec};
    assign live_v[1] = {1'b0, live_min};
    assign live_v[2] = {2'b0, live_hour};
    assign live_v[3] = {2'b0, live_day};
    assign live_v[4] = {3'b0, live_mon};
    assign live_v[5] = live_year;

    tstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (tamper_n),
        .fall  (fall)
    );

    tstamp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (fall),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .cap_go  (cap_go),
        .flag1_q (flag1),
        .flag2_q (flag2),
        .ien_q   (ien),
        .mode_q  (mode),
        .dis_q   (dis),
        .irq_n   (irq_n)
    );

    tstamp_snap u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_go (cap_go),
        .live   (live_v),
        .snap_q (snap)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_FLAG1) reg_rdata[B_FLAG1] = flag1;
        if (reg_addr == A_FLAG2) begin
            reg_rdata[B_FLAG2] = flag2;
            reg_rdata[B_IEN]   = ien;
        end
        if (reg_addr == A_CFG) begin
            reg_rdata[B_MODE] = mode;
            reg_rdata[B_DIS]  = dis;
        end
        for (int i = 0; i < N_FIELDS; i++) begin
            if (reg_addr == ADDR_W'(A_SNAP0 + i)) reg_rdata = snap[i];
        end
    end

    // R11
    high_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(A_SNAP0 + N_FIELDS)) |-> (reg_rdata == '0));
endmodule

// File: tb/tamper_stamp_bench.sv
`timescale 1ns/1ps
module tamper_stamp_bench;
    logic       clk = 1'b0;
    logic       rst_n, tamper_n, reg_we, irq_n;
    logic [6:0] live_sec, live_min;
    logic [5:0] live_hour, live_day;
    logic [4:0] live_mon;
    logic [7:0] live_year, reg_wdata, reg_rdata;
    logic [3:0] reg_addr;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    int   wid [6] = '{7, 7, 6, 6, 5, 8};
    logic [7:0] expv [6];
    logic       ien = 1'b0;

    always #4 clk = ~clk;

    tamper_stamp u_tamper_stamp (
        .clk(clk), .rst_n(rst_n), .tamper_n(tamper_n),
        .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
        .live_day(live_day), .live_mon(live_mon), .live_year(live_year),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic setl(input logic [7:0] v [6]);
        live_sec = v[0][6:0]; live_min = v[1][6:0]; live_hour = v[2][5:0];
        live_day = v[3][5:0]; live_mon = v[4][4:0]; live_year = v[5];
    endtask

    function automatic logic [7:0] msk(input int i, input logic [7:0] x);
        return x & 8'((1 << wid[i]) - 1);
    endfunction

    // Event whose capture edge sees v; live differs one cycle before and after.
    task automatic fire(input logic [7:0] v [6], input bit clr_on_edge);
        logic [7:0] inv [6];
        for (int i = 0; i < 6; i++) inv[i] = ~v[i];
        setl(inv);
        @(negedge clk); tamper_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); setl(v);
        if (clr_on_edge) begin
            reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h00;
        end
        @(posedge clk);
        @(negedge clk); setl(inv); reg_we = 1'b0;
        repeat (3) @(negedge clk);
        tamper_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_snap(input string req);
        logic [7:0] d;
        for (int i = 0; i < 6; i++) begin
            rd(4'(3 + i), d);
            chk(req, $sformatf("field%0d", i), d, expv[i]);
        end
    endtask

    task automatic chk_flags(input string req, input logic f1, input logic f2);
        logic [7:0] d;
        rd(4'd0, d);
        chk(req, "flag1 reg", d, {3'b0, f1, 4'b0});
        rd(4'd1, d);
        chk(req, "flag2 reg", d, {2'b0, f2, 2'b0, ien, 2'b0});
    endtask

    task automatic mkv(input int n, output logic [7:0] v [6]);
        for (int i = 0; i < 6; i++) v[i] = 8'((n * 37 + i * 11 + 3) & 255);
    endtask

    task automatic learn(input logic [7:0] v [6]);
        for (int i = 0; i < 6; i++) expv[i] = msk(i, v[i]);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v [6];
        logic [7:0] d;
        rst_n = 1'b0; tamper_n = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int i = 0; i < 6; i++) v[i] = 8'h00;
        setl(v);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "irq_n", {7'b0, irq_n}, 8'h01);
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            chk("R1", $sformatf("addr%0d", a), d, 8'h00);
        end
        // R11: unused addresses
        for (int a = 9; a < 16; a++) begin
            rd(4'(a), d);
            chk("R11", $sformatf("addr%0d", a), d, 8'h00);
        end

        // R2 R7 R3: overwrite sweep, including all-ones fields
        for (int i = 0; i < 6; i++) v[i] = 8'hFF;
        fire(v, 0); learn(v);
        chk_snap("R2");
        chk_flags("R3", 1'b1, 1'b1);
        for (int n = 0; n < 16; n++) begin
            mkv(n, v);
            fire(v, 0); learn(v);
            chk_snap("R7");
            chk_flags("R3", 1'b1, 1'b1);
        end

        // R9: steady levels and the rising edge leave the snapshot alone
        mkv(99, v); setl(v);
        repeat (10) @(negedge clk);
        chk_snap("R9");

        // R4: clear individually, write-one has no effect
        wr(4'd0, 8'hEF);
        chk_flags("R4", 1'b0, 1'b1);
        wr(4'd1, 8'h10);
        chk_flags("R4", 1'b0, 1'b0);
        mkv(40, v); fire(v, 0); learn(v);
        wr(4'd0, 8'h10); wr(4'd1, 8'h20);
        chk_flags("R4", 1'b1, 1'b1);

        // R8: interrupt gating
        chk("R8", "irq_n ien=0", {7'b0, irq_n}, 8'h01);
        wr(4'd1, 8'h24); ien = 1'b1;
        chk("R8", "irq_n both flags", {7'b0, irq_n}, 8'h00);
        wr(4'd0, 8'h00);
        chk("R8", "irq_n flag2 only", {7'b0, irq_n}, 8'h00);
        wr(4'd1, 8'h04);
        chk("R8", "irq_n no flags", {7'b0, irq_n}, 8'h01);
        mkv(41, v); fire(v, 0); learn(v);
        chk("R8", "irq_n after event", {7'b0, irq_n}, 8'h00);
        wr(4'd1, 8'h00); ien = 1'b0;
        chk("R8", "irq_n disabled", {7'b0, irq_n}, 8'h01);
        wr(4'd0, 8'h00);

        // R6: keep-first mode
        wr(4'd2, 8'h80);
        rd(4'd2, d);
        chk("R6", "cfg reg", d, 8'h80);
        mkv(50, v); fire(v, 0); learn(v);
        chk_snap("R6");
        mkv(51, v); fire(v, 0);
        chk_snap("R6");
        wr(4'd0, 8'h00);
        mkv(52, v); fire(v, 0);
        chk_snap("R6");
        chk_flags("R6", 1'b0, 1'b1);
        wr(4'd1, 8'h00);
        mkv(53, v); fire(v, 0); learn(v);
        chk_snap("R6");
        chk_flags("R6", 1'b1, 1'b1);

        // R5: capture disabled, then enabled again
        wr(4'd2, 8'h40); wr(4'd0, 8'h00); wr(4'd1, 8'h00);
        mkv(60, v); fire(v, 0);
        chk_snap("R5");
        chk_flags("R5", 1'b0, 1'b0);
        wr(4'd2, 8'h00);
        mkv(61, v); fire(v, 0); learn(v);
        chk_snap("R5");
        chk_flags("R5", 1'b1, 1'b1);

        // R10: capture and clearing write on the same edge
        mkv(70, v); fire(v, 1); learn(v);
        chk_flags("R10", 1'b1, 1'b1);
        chk_snap("R10");

        // R11: snapshot addresses are read-only
        for (int a = 3; a < 9; a++) wr(4'(a), 8'h5A);
        chk_snap("R11");

        done = 1;
        summary();
        $finish;
    end
endmodule